// File: doc/BRIEF.md
# Residual Systematic Resampling Datapath

This block turns a stream of normalized particle weights into one replication count per particle, for use by a particle filter's resampling stage. Software or an upstream sequencer starts a run by giving the particle count and a uniform random offset. It then streams the weights in index order, at most one per clock. For each weight the block returns the number of copies the resampled set should hold of that particle. It returns the particle's index alongside the count and flags the last result.

The block carries a scaled residual from one particle to the next instead of comparing a cumulative sum against a moving threshold. A run therefore costs exactly one iteration per particle, whatever the shape of the weights. The residual update closes inside a single clock, so a new weight can enter every cycle. An input register and the residual register form a two-stage pipeline, which gives a run of M particles a length of M plus two cycles. Expanding counts into index lists and drawing the random offset are left to the neighbouring blocks.

Top module: `rsr_datapath`

## Requirements
- R1: After synchronous reset, out_valid and out_done are low and the block is idle, ready to accept start.
- R2: A start pulse while idle latches m_len (1..64) and u_init. The block then accepts exactly m_len weights, one on each following cycle where w_valid is high. Weights beyond the m_len-th are not taken.
- R3: Weights are unsigned Q1.16 (1.0 = 65536, summing to exactly 65536), and u_init is unsigned Q0.16 with 0 < u_init < 65536/m_len. With U(-1) = u_init, the count is r(m) = max(0, floor((w(m) - U(m-1))*M) + 1). The residual then becomes U(m) = U(m-1) + r(m)/M - w(m), computed without rounding error.
- R4: The counts equal those of systematic resampling with thresholds u_init + k/M, k = 0..M-1. Particle m receives every threshold t with C(m-1) < t <= C(m), where C is the running weight sum. For weights 0.4, 0.04, 0.04, 0.52, 0 and u_init = 0.1, the counts are 2, 0, 0, 3, 0.
- R5: The counts of one run sum to m_len.
- R6: The count for a weight accepted in cycle A is on the outputs during cycle A+2. Idle cycles between weights leave the carried residual unchanged.
- R7: out_idx gives the particle index of each result, starting at 0 and rising by one per result within a run.
- R8: out_done is high together with the result of particle m_len-1, and at no other time.
- R9: While no run is active, w_valid has no effect. A start pulse that arrives before the run's last result has been produced is ignored.
- R10: A particle of weight zero gets a count of 0. A single particle holding weight 1.0 gets all m_len copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| m_len | input | 7 | Particle count for the run, 1..64 |
| u_init | input | 16 | Random offset, Q0.16, below 1/m_len |
| w_valid | input | 1 | A weight is present on w_data |
| w_data | input | 17 | Particle weight, Q1.16 |
| out_valid | output | 1 | Result present |
| out_idx | output | 6 | Particle index of the result |
| out_rep | output | 7 | Replication count |
| out_done | output | 1 | Result belongs to the last particle |

## Verification
The hardest case to reach is a residual that must survive both pipeline bubbles and long stretches of zero-weight particles without drifting. A bubble that disturbed it, or a zero weight that nudged it, would only show up several particles later. The stimulus inserts idle cycles inside runs and uses weight vectors with zero-weight particles, one particle holding all the weight, and a 64-particle run. The expected counts come from an independent threshold-counting model of systematic resampling, so any drift in the carried residual shows up as a wrong count.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    parameter int N_MAX  = 64;
    parameter int FRAC_W = 16;

    localparam int W_W    = FRAC_W + 1;
    localparam int IDX_W  = $clog2(N_MAX);
    localparam int MCNT_W = $clog2(N_MAX + 1);
    localparam int CNT_W  = $clog2(N_MAX + 2);
    localparam int WM_W   = W_W + MCNT_W;
    localparam int D_W    = WM_W + 1;

    localparam logic signed [D_W-1:0] ONE_D = {{(D_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
    localparam logic signed [D_W-1:0] LSB_D = {{(D_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             vld;
        logic             last;
        logic [IDX_W-1:0] idx;
        logic [WM_W-1:0]  wm;
    } scaled_t;

    typedef struct packed {
        logic             vld;
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] rep;
    } result_t;

    // count = floor(d) + 1, clamped at zero (d is in units of 2^-FRAC_W)
    function automatic logic [CNT_W-1:0] count_of(input logic signed [D_W-1:0] d);
        logic signed [D_W-1:0] c;
        c = (d >>> FRAC_W) + LSB_D;
        if (c < 0) return '0;
        return c[CNT_W-1:0];
    endfunction

    // scaled residual carried forward: count * 1.0 - d
    function automatic logic signed [D_W-1:0] carry_of(input logic signed [D_W-1:0] d,
                                                        input logic [CNT_W-1:0]     c);
        logic signed [D_W-1:0] ext;
        ext = $signed({{(D_W-CNT_W-FRAC_W){1'b0}}, c, {FRAC_W{1'b0}}});
        return ext - d;
    endfunction
endpackage

// File: rtl/rsr_seq.sv
module rsr_seq
    import rsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MCNT_W-1:0] m_len,
    input  logic              w_valid,
    input  logic              pipe_busy,
    output logic              load,
    output logic              take,
    output logic              take_last,
    output logic [IDX_W-1:0]  take_idx,
    output logic [MCNT_W-1:0] m_q
);
    logic             active_q;
    logic [IDX_W-1:0] idx_q;

    assign load      = start && !active_q && !pipe_busy;
    assign take      = active_q && w_valid;
    assign take_idx  = idx_q;
    assign take_last = (MCNT_W'(idx_q) + MCNT_W'(1)) == m_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            m_q      <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            m_q      <= m_len;
        end else if (take) begin
            idx_q <= idx_q + IDX_W'(1);
            if (take_last) active_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rsr_scale.sv
module rsr_scale
    import rsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              take_last,
    input  logic [IDX_W-1:0]  take_idx,
    input  logic [W_W-1:0]    w_data,
    input  logic [MCNT_W-1:0] m_q,
    output scaled_t           s1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld  <= take;
            s1.last <= take && take_last;
            s1.idx  <= take_idx;
            s1.wm   <= {{MCNT_W{1'b0}}, w_data} * {{W_W{1'b0}}, m_q};
        end
    end
endmodule

// File: rtl/rsr_core.sv
module rsr_core
    import rsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [FRAC_W-1:0] u_init,
    input  logic [MCNT_W-1:0] m_len,
    input  scaled_t           s1,
    output result_t           res
);
    logic signed [D_W-1:0]          rsd_q;
    logic [FRAC_W+MCNT_W-1:0]       v0;
    logic signed [D_W-1:0]          diff;
    logic [CNT_W-1:0]               cnt;
    logic signed [D_W-1:0]          rsd_nxt;

    always_comb begin
        v0      = {{MCNT_W{1'b0}}, u_init} * {{FRAC_W{1'b0}}, m_len};
        diff    = $signed({1'b0, s1.wm}) - rsd_q;
        cnt     = count_of(diff);
        rsd_nxt = carry_of(diff, cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsd_q <= '0;
            res   <= '0;
        end else begin
            res.vld  <= s1.vld;
            res.done <= s1.vld && s1.last;
            res.idx  <= s1.idx;
            res.rep  <= cnt;
            if (load)
                rsd_q <= $signed({{(D_W-FRAC_W-MCNT_W){1'b0}}, v0});
            else if (s1.vld)
                rsd_q <= rsd_nxt;
        end
    end
endmodule

// File: rtl/rsr_datapath.sv
module rsr_datapath
    import rsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MCNT_W-1:0] m_len,
    input  logic [FRAC_W-1:0] u_init,
    input  logic              w_valid,
    input  logic [W_W-1:0]    w_data,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic [CNT_W-1:0]  out_rep,
    output logic              out_done
);
    logic              load, take, take_last;
    logic [IDX_W-1:0]  take_idx;
    logic [MCNT_W-1:0] m_q;
    scaled_t           s1;
    result_t           res;

    rsr_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .m_len(m_len), .w_valid(w_valid),
        .pipe_busy(s1.vld), .load(load), .take(take), .take_last(take_last),
        .take_idx(take_idx), .m_q(m_q)
    );

    rsr_scale u_scale (
        .clk(clk), .rst(rst), .take(take), .take_last(take_last),
        .take_idx(take_idx), .w_data(w_data), .m_q(m_q), .s1(s1)
    );

    rsr_core u_core (
        .clk(clk), .rst(rst), .load(load), .u_init(u_init), .m_len(m_len),
        .s1(s1), .res(res)
    );

    assign out_valid = res.vld;
    assign out_idx   = res.idx;
    assign out_rep   = res.rep;
    assign out_done  = res.done;
endmodule

// File: rtl/rsr_checker.sv
module rsr_checker
    import rsr_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  out_valid,
    input logic                  out_done,
    input logic [IDX_W-1:0]      out_idx,
    input logic [CNT_W-1:0]      out_rep,
    input logic                  w_take,
    input logic [MCNT_W-1:0]     m_run,
    input logic signed [D_W-1:0] rsd
);
    logic [15:0] sum_acc;

    always_ff @(posedge clk) begin
        if (rst || out_done) sum_acc <= '0;
        else if (out_valid)  sum_acc <= sum_acc + 16'(out_rep);
    end

    // R3: carried residual stays within [0, 1.0] in scaled units
    a_r3_residual_range: assert property (@(posedge clk) disable iff (rst)
        (rsd >= 0) && (rsd <= ONE_D));

    // R5: counts of a run add up to the particle count
    a_r5_count_sum: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (sum_acc + 16'(out_rep)) == 16'(m_run));

    // R6: result two cycles after acceptance
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        w_take |=> ##1 out_valid);

    // R7: indices rise by one within a run
    a_r7_index_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_done) |=> (!out_valid || out_idx == $past(out_idx) + IDX_W'(1)));

    // R8: done only with a result
    a_r8_done_valid: assert property (@(posedge clk) disable iff (rst)
        out_done |-> out_valid);
endmodule

bind rsr_datapath rsr_checker u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_done(out_done),
    .out_idx(out_idx), .out_rep(out_rep), .w_take(take), .m_run(m_q),
    .rsd(u_core.rsd_q)
);

// File: tb/tb_rsr_datapath.sv
module tb_rsr_datapath;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  m_len = '0;
    logic [15:0] u_init = '0;
    logic        w_valid = 1'b0;
    logic [16:0] w_data = '0;
    logic        out_valid, out_done;
    logic [5:0]  out_idx;
    logic [6:0]  out_rep;

    rsr_datapath dut (
        .clk(clk), .rst(rst), .start(start), .m_len(m_len), .u_init(u_init),
        .w_valid(w_valid), .w_data(w_data), .out_valid(out_valid),
        .out_idx(out_idx), .out_rep(out_rep), .out_done(out_done)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int wv[64], exp_rep[64], in_cyc[64];
    int got_idx[64], got_rep[64], got_cyc[64], got_done[64];
    int got_n = 0;

    always @(negedge clk) begin
        if (out_valid && got_n < 64) begin
            got_idx[got_n]  = int'(out_idx);
            got_rep[got_n]  = int'(out_rep);
            got_cyc[got_n]  = cyc;
            got_done[got_n] = int'(out_done);
            got_n++;
        end
    end

    localparam int NV = 6;
    localparam int TM[NV] = '{5, 4, 8, 3, 1, 7};
    localparam int TU[NV] = '{6554, 1000, 7000, 21845, 30000, 9000};
    localparam int TW[NV][8] = '{
        '{26214, 2621, 2621, 34080, 0, 0, 0, 0},
        '{16384, 16384, 16384, 16384, 0, 0, 0, 0},
        '{0, 20000, 5000, 0, 30000, 500, 10036, 0},
        '{65536, 0, 0, 0, 0, 0, 0, 0},
        '{65536, 0, 0, 0, 0, 0, 0, 0},
        '{9362, 9362, 9362, 9362, 9362, 9362, 9364, 0}
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // threshold-counting model of systematic resampling
    task automatic model(input int m, input int u);
        longint prev, cum, thr;
        prev = 0;
        cum  = 0;
        for (int j = 0; j < m; j++) begin
            cum = cum + longint'(wv[j]);
            exp_rep[j] = 0;
            for (int k = 0; k < m; k++) begin
                thr = longint'(u) * m + longint'(k) * 65536;
                if (thr > prev * m && thr <= cum * m) exp_rep[j]++;
            end
            prev = cum;
        end
    endtask

    task automatic run(input int m, input int u, input bit gaps, input bit poke);
        int sum;
        model(m, u);
        got_n = 0;
        @(negedge clk);
        start = 1'b1; m_len = 7'(m); u_init = 16'(u);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < m; i++) begin
            if (gaps && (i % 3 == 1)) begin
                w_valid = 1'b0;
                @(negedge clk);
            end
            w_valid = 1'b1; w_data = 17'(wv[i]); in_cyc[i] = cyc;
            if (poke && i == 1) begin
                start = 1'b1; m_len = 7'd2; u_init = 16'd100;
            end
            @(negedge clk);
            start = 1'b0;
        end
        // extra weights after the run must not be taken (R2, R9)
        w_valid = 1'b1; w_data = 17'd65536;
        repeat (3) @(negedge clk);
        w_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(got_n == m, "R2 result count", got_n, m);
        sum = 0;
        for (int i = 0; i < m && i < got_n; i++) begin
            check(got_rep[i] == exp_rep[i], "R4 count vs systematic", got_rep[i], exp_rep[i]);
            check(got_idx[i] == i, "R7 index", got_idx[i], i);
            check(got_cyc[i] == in_cyc[i] + 2, "R6 latency", got_cyc[i], in_cyc[i] + 2);
            check(got_done[i] == ((i == m - 1) ? 1 : 0), "R8 done flag", got_done[i], (i == m - 1) ? 1 : 0);
            sum += got_rep[i];
        end
        check(sum == m, "R5 count sum", sum, m);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        check(out_done == 1'b0, "R1 done after reset", int'(out_done), 0);

        // R9: weights while idle are ignored
        got_n = 0;
        w_valid = 1'b1; w_data = 17'd40000;
        repeat (4) @(negedge clk);
        w_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(got_n == 0, "R9 idle weights ignored", got_n, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 8; i++) wv[i] = TW[v][i];
            run(TM[v], TU[v], (v % 2) == 1, 1'b0);
            if (v == 0) begin
                // R4 worked example
                check(got_rep[0] == 2 && got_rep[1] == 0 && got_rep[2] == 0 &&
                      got_rep[3] == 3 && got_rep[4] == 0, "R4 example 2,0,0,3,0", got_rep[3], 3);
                // R3 explicit first count: floor((0.4-0.1)*5)+1 = 2
                check(got_rep[0] == 2, "R3 first count", got_rep[0], 2);
            end
            if (v == 3) begin
                check(got_rep[0] == 3, "R10 full weight gets all", got_rep[0], 3);
                check(got_rep[1] == 0 && got_rep[2] == 0, "R10 zero weight", got_rep[1], 0);
            end
            if (v == 2) check(got_rep[0] == 0, "R10 leading zero weight", got_rep[0], 0);
        end

        // R3/R6: 64 equal weights with gaps, each gets one
        for (int i = 0; i < 64; i++) wv[i] = 1024;
        run(64, 500, 1'b1, 1'b0);
        for (int i = 0; i < 64; i++)
            if (got_rep[i] != 1) check(1'b0, "R3 uniform count", got_rep[i], 1);
        check(1'b1, "R3 uniform run", 1, 1);

        // R10: sparse weights, every fourth particle gets four
        for (int i = 0; i < 64; i++) wv[i] = (i % 4 == 0) ? 4096 : 0;
        run(64, 1, 1'b0, 1'b0);
        check(got_rep[4] == 4 && got_rep[5] == 0, "R10 sparse counts", got_rep[4], 4);

        // R9: start while busy ignored
        for (int i = 0; i < 8; i++) wv[i] = TW[2][i];
        run(8, 7000, 1'b0, 1'b1);

        // R1: reset in the middle of a run
        @(negedge clk);
        start = 1'b1; m_len = 7'd8; u_init = 16'd10;
        @(negedge clk);
        start = 1'b0; w_valid = 1'b1; w_data = 17'd8192;
        repeat (2) @(negedge clk);
        rst = 1'b1; w_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after mid-run reset", int'(out_valid), 0);
        for (int i = 0; i < 8; i++) wv[i] = TW[0][i];
        run(5, 6554, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule